// File: doc/BRIEF.md
# Action/Value Command Register Front End

This block is the software-facing control port of an error-record store. Software sees a 16-byte window holding two 64-bit registers: an action register at byte offset 0 and a value register at byte offset 8. The usual sequence is to place an argument in the value register and then write an action code to the action register. The block carries out that action at once. It can latch the current operation, copy the value register into the record offset or the record identifier, or load an answer (busy flag, command status, record count, record size, attributes, timing window) back into the value register for software to read.

The execute action runs only when the low byte of the value register holds a fixed key. For the three operations that move records (write, read, clear), the block raises a one-cycle start pulse to a separate record engine. It stays busy until the engine answers with a done pulse, and then takes the engine's status as the command status. The end and dummy-write operations complete locally with success. Reads of the window never change state.

Top module: `actval_ctrl`

## Requirements
- R1: After reset both registers read 0, the latched operation, record offset and record identifier are 0, no start pulse is issued, and a command-status query (action 7) returns 0, the success code.
- R2: A 64-bit access to offset 8 reads or writes the whole value register. A 32-bit access at offset 12 (address bit 2 set) reads or writes only bits 63:32, and one at offset 8 only bits 31:0. A 32-bit write leaves the other half unchanged, and a 32-bit read returns the selected half in bits 31:0.
- R3: Action codes 0x0, 0x1, 0x2, 0x3 and 0xB only store the code as the current operation, which is driven on `eng_op`.
- R4: Action 0x4 copies the value register into the record offset (`eng_offset`), and action 0x9 copies it into the record identifier (`eng_rec_id`).
- R5: Action 0x5 with 0x9C in value bits 7:0, while operation 0x0, 0x1 or 0x2 is latched, sets busy and pulses `eng_start` for exactly one cycle in the same clock edge. Busy holds until a cycle with `eng_done` high, and `eng_status` from that cycle becomes the command status.
- R6: Action 0x5 has no effect when value bits 7:0 differ from 0x9C: no start pulse, busy stays clear, and the command status is unchanged.
- R7: A keyed execute while operation 0x3 or 0xB is latched completes at once with status 0 (success) and issues no start pulse. Status 3 (failed) is reserved for any other latched code.
- R8: Queries load the value register as follows: action 0x6 loads the busy flag in bit 0, action 0x7 loads the 8-bit command status, action 0xA loads the `rec_count` input, action 0xE loads the record size in bytes, and action 0xF loads 0.
- R9: Action 0x10 loads the value register with 100 in bits 63:32 (maximum time) and 10 in bits 31:0 (minimum time).
- R10: An unknown action code has no effect. A write to offset 4, a write to an address that is not 4-byte aligned, and a 64-bit write at offset 12 are all ignored.
- R11: While busy, every action write except 0x6 and 0x7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one access |
| addr | input | 4 | Byte address inside the 16-byte window |
| is64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wdata | input | 64 | Write data; a 32-bit access uses bits 31:0 |
| rdata | output | 64 | Read data for the current `addr` and `is64` (combinational) |
| rec_count | input | CNT_W | Number of stored records, supplied by slot bookkeeping |
| eng_start | output | 1 | One-cycle start pulse to the record engine |
| eng_op | output | 8 | Latched operation code |
| eng_offset | output | OFF_W | Latched record offset |
| eng_rec_id | output | 64 | Latched record identifier |
| eng_done | input | 1 | Engine completion pulse |
| eng_status | input | 8 | Engine result code, valid while `eng_done` is high |

## Verification
The busy-release check assumes the record engine pulses `eng_done` only after a start pulse, and only while the block is busy. The bench's engine model drives done only in that window, for one cycle, at least one cycle after the start pulse. The port takes one access per cycle. Stimulus is applied on the falling edge, and each write is held for exactly one rising edge, so no access overlaps a done pulse.

// File: rtl/acv_pkg.sv
package acv_pkg;

  localparam int WORD_W = 64;
  localparam int HALF_W = 32;

  // action codes (compared against bits 31:0 of an action write)
  localparam logic [31:0] A_BEG_WR  = 32'h00;
  localparam logic [31:0] A_BEG_RD  = 32'h01;
  localparam logic [31:0] A_BEG_CLR = 32'h02;
  localparam logic [31:0] A_END     = 32'h03;
  localparam logic [31:0] A_SET_OFF = 32'h04;
  localparam logic [31:0] A_EXEC    = 32'h05;
  localparam logic [31:0] A_Q_BUSY  = 32'h06;
  localparam logic [31:0] A_Q_STAT  = 32'h07;
  localparam logic [31:0] A_SET_ID  = 32'h09;
  localparam logic [31:0] A_Q_COUNT = 32'h0A;
  localparam logic [31:0] A_DUMMY   = 32'h0B;
  localparam logic [31:0] A_Q_SIZE  = 32'h0E;
  localparam logic [31:0] A_Q_ATTR  = 32'h0F;
  localparam logic [31:0] A_Q_TIME  = 32'h10;

  typedef enum logic [7:0] {
    ST_OK        = 8'd0,
    ST_NO_SPACE  = 8'd1,
    ST_HW_ABSENT = 8'd2,
    ST_FAILED    = 8'd3,
    ST_EMPTY     = 8'd4,
    ST_NOT_FOUND = 8'd5
  } cmd_status_e;

  // merge a write into a 64-bit register, half-selected for 32-bit access
  function automatic logic [WORD_W-1:0] merge_word(
      input logic [WORD_W-1:0] old_w, input logic [WORD_W-1:0] data,
      input logic wide, input logic upper);
    if (wide)       return data;
    else if (upper) return {data[HALF_W-1:0], old_w[HALF_W-1:0]};
    else            return {old_w[WORD_W-1:HALF_W], data[HALF_W-1:0]};
  endfunction

  // read view of a 64-bit register for a given access width and half
  function automatic logic [WORD_W-1:0] pick_word(
      input logic [WORD_W-1:0] w, input logic wide, input logic upper);
    if (wide)       return w;
    else if (upper) return {{HALF_W{1'b0}}, w[WORD_W-1:HALF_W]};
    else            return {{HALF_W{1'b0}}, w[HALF_W-1:0]};
  endfunction

  function automatic logic is_op_code(input logic [31:0] c);
    return (c == A_BEG_WR) || (c == A_BEG_RD) || (c == A_BEG_CLR) ||
           (c == A_END) || (c == A_DUMMY);
  endfunction

  function automatic logic is_engine_op(input logic [7:0] op);
    return (op == A_BEG_WR[7:0]) || (op == A_BEG_RD[7:0]) || (op == A_BEG_CLR[7:0]);
  endfunction

  function automatic logic is_local_ok(input logic [7:0] op);
    return (op == A_END[7:0]) || (op == A_DUMMY[7:0]);
  endfunction

endpackage

// File: rtl/acv_bus_decode.sv
module acv_bus_decode (
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic       is64,
  output logic       val_wr,
  output logic       act_wr,
  output logic       sel_hi
);
  logic aligned;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    sel_hi  = addr[2];
    // value register: offsets 8 and 12; a wide access must start at 8
    val_wr  = wr_en && aligned && addr[3] && (!is64 || !addr[2]);
    // action register: only offset 0 carries meaning
    act_wr  = wr_en && aligned && !addr[3] && !addr[2];
  end
endmodule

// File: rtl/acv_value_reg.sv
module acv_value_reg
  import acv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              wide,
  input  logic              upper,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (bus_wr) q <= merge_word(q, bus_data, wide, upper);
    else if (ld_en)  q <= ld_data;
  end
endmodule

// File: rtl/acv_action_dec.sv
module acv_action_dec
  import acv_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter int          REC_BYTES = 8192,
  parameter logic [7:0]  KEY       = 8'h9C,
  parameter int          T_MAX     = 100,
  parameter int          T_MIN     = 10
) (
  input  logic              act_wr,
  input  logic [31:0]       code,
  input  logic              busy,
  input  logic [7:0]        key_byte,
  input  logic [7:0]        status,
  input  logic [CNT_W-1:0]  rec_count,
  output logic              accept,
  output logic              latch_op,
  output logic              set_off,
  output logic              set_id,
  output logic              exec_go,
  output logic              ld_en,
  output logic [WORD_W-1:0] ld_data
);
  always_comb begin
    accept   = act_wr && (!busy || code == A_Q_BUSY || code == A_Q_STAT);
    latch_op = accept && is_op_code(code);
    set_off  = accept && (code == A_SET_OFF);
    set_id   = accept && (code == A_SET_ID);
    exec_go  = accept && (code == A_EXEC) && (key_byte == KEY);
    ld_en    = 1'b0;
    ld_data  = '0;
    if (accept) begin
      case (code)
        A_Q_BUSY:  begin ld_en = 1'b1; ld_data = WORD_W'(busy); end
        A_Q_STAT:  begin ld_en = 1'b1; ld_data = WORD_W'(status); end
        A_Q_COUNT: begin ld_en = 1'b1; ld_data = WORD_W'(rec_count); end
        A_Q_SIZE:  begin ld_en = 1'b1; ld_data = WORD_W'(REC_BYTES); end
        A_Q_ATTR:  begin ld_en = 1'b1; ld_data = '0; end
        A_Q_TIME:  begin ld_en = 1'b1; ld_data = {HALF_W'(T_MAX), HALF_W'(T_MIN)}; end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/acv_exec_ctl.sv
module acv_exec_ctl
  import acv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_go,
  input  logic [7:0] op,
  input  logic       eng_done,
  input  logic [7:0] eng_status,
  output logic       busy,
  output logic       start,
  output logic [7:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      start  <= 1'b0;
      status <= ST_OK;
    end else begin
      start <= 1'b0;
      if (busy && eng_done) begin
        busy   <= 1'b0;
        status <= eng_status;
      end else if (exec_go) begin
        if (is_engine_op(op)) begin
          busy  <= 1'b1;
          start <= 1'b1;
        end else begin
          status <= is_local_ok(op) ? ST_OK : ST_FAILED;
        end
      end
    end
  end
endmodule

// File: rtl/actval_ctrl.sv
module actval_ctrl
  import acv_pkg::*;
#(
  parameter int         CNT_W     = 32,
  parameter int         OFF_W     = 32,
  parameter int         REC_BYTES = 8192,
  parameter logic [7:0] KEY       = 8'h9C,
  parameter int         T_MAX     = 100,
  parameter int         T_MIN     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic              is64,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [CNT_W-1:0]  rec_count,
  output logic              eng_start,
  output logic [7:0]        eng_op,
  output logic [OFF_W-1:0]  eng_offset,
  output logic [63:0]       eng_rec_id,
  input  logic              eng_done,
  input  logic [7:0]        eng_status
);
  // named internal events, observed by the bound checker
  logic              val_wr, act_wr, sel_hi;
  logic              accept, latch_op, set_off, set_id, exec_go, ld_en;
  logic [WORD_W-1:0] ld_data, val_q;
  logic [31:0]       act_q;
  logic              busy;
  logic [7:0]        status;

  acv_bus_decode u_bus (
    .wr_en(wr_en), .addr(addr), .is64(is64),
    .val_wr(val_wr), .act_wr(act_wr), .sel_hi(sel_hi)
  );

  acv_action_dec #(
    .CNT_W(CNT_W), .REC_BYTES(REC_BYTES), .KEY(KEY), .T_MAX(T_MAX), .T_MIN(T_MIN)
  ) u_dec (
    .act_wr(act_wr), .code(wdata[31:0]), .busy(busy), .key_byte(val_q[7:0]),
    .status(status), .rec_count(rec_count), .accept(accept),
    .latch_op(latch_op), .set_off(set_off), .set_id(set_id),
    .exec_go(exec_go), .ld_en(ld_en), .ld_data(ld_data)
  );

  acv_value_reg u_val (
    .clk(clk), .rst_n(rst_n), .bus_wr(val_wr), .bus_data(wdata),
    .wide(is64), .upper(sel_hi), .ld_en(ld_en), .ld_data(ld_data), .q(val_q)
  );

  acv_exec_ctl u_exec (
    .clk(clk), .rst_n(rst_n), .exec_go(exec_go), .op(eng_op),
    .eng_done(eng_done), .eng_status(eng_status),
    .busy(busy), .start(eng_start), .status(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= '0;
      eng_op     <= '0;
      eng_offset <= '0;
      eng_rec_id <= '0;
    end else begin
      if (act_wr)   act_q      <= wdata[31:0];
      if (latch_op) eng_op     <= wdata[7:0];
      if (set_off)  eng_offset <= val_q[OFF_W-1:0];
      if (set_id)   eng_rec_id <= val_q;
    end
  end

  always_comb begin
    if (addr[1:0] != 2'b00)
      rdata = '0;
    else if (addr[3])
      rdata = pick_word(val_q, is64, sel_hi);
    else
      rdata = pick_word({32'b0, act_q}, is64, sel_hi);
  end

endmodule

// File: rtl/acv_chk.sv
module acv_chk #(
  parameter logic [7:0] KEY = 8'h9C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        start,
  input logic        done,
  input logic        act_wr,
  input logic [31:0] code,
  input logic [63:0] val_q,
  input logic [63:0] rec_id
);
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  // R6
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && act_wr && code == 32'h5 && val_q[7:0] != KEY) |=> (!start && !busy));
  // R4
  id_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && act_wr && code == 32'h9) |=> (rec_id == $past(val_q)));
  // R11
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_wr && code == 32'h9) |=> $stable(rec_id));
endmodule

bind actval_ctrl acv_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(eng_start), .done(eng_done),
  .act_wr(act_wr), .code(wdata[31:0]), .val_q(val_q), .rec_id(eng_rec_id)
);

// File: tb/sim_actval_ctrl.sv
module sim_actval_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic        is64 = 1'b1;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] rec_count = 32'd37;
  logic        eng_start;
  logic [7:0]  eng_op;
  logic [31:0] eng_offset;
  logic [63:0] eng_rec_id;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_status = 8'd0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  actval_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .is64(is64),
    .wdata(wdata), .rdata(rdata), .rec_count(rec_count),
    .eng_start(eng_start), .eng_op(eng_op), .eng_offset(eng_offset),
    .eng_rec_id(eng_rec_id), .eng_done(eng_done), .eng_status(eng_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d, input logic w64);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; is64 = w64;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic act(input logic [31:0] c);
    wr(4'h0, {32'b0, c}, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, input logic w64, output logic [63:0] v);
    addr = a; is64 = w64;
    #1 v = rdata;
  endtask

  task automatic query(input logic [31:0] c, output logic [63:0] v);
    act(c);
    rd(4'h8, 1'b1, v);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(4'h8, 1'b1, v);  chk("R1 value", v, 64'h0);
    rd(4'h0, 1'b1, v);  chk("R1 action", v, 64'h0);
    chk("R1 start", {63'b0, eng_start}, 64'h0);
    chk("R1 op", {56'b0, eng_op}, 64'h0);
    chk("R1 offset", {32'b0, eng_offset}, 64'h0);
    chk("R1 id", eng_rec_id, 64'h0);
    query(32'h7, v);    chk("R1 status", v, 64'h0);
  endtask

  task automatic t_merge;
    logic [63:0] v;
    wr(4'h8, 64'h1122334455667788, 1'b1);
    rd(4'h8, 1'b1, v);  chk("R2 wide", v, 64'h1122334455667788);
    wr(4'hC, 64'h00000000AABBCCDD, 1'b0);
    rd(4'h8, 1'b1, v);  chk("R2 upper write", v, 64'hAABBCCDD55667788);
    rd(4'h8, 1'b0, v);  chk("R2 low read", v, 64'h55667788);
    rd(4'hC, 1'b0, v);  chk("R2 high read", v, 64'hAABBCCDD);
    wr(4'h8, 64'hFFFFFFFF01020304, 1'b0);
    rd(4'h8, 1'b1, v);  chk("R2 lower write", v, 64'hAABBCCDD01020304);
  endtask

  task automatic t_latch;
    logic [7:0] codes [5] = '{8'h1, 8'h2, 8'h3, 8'hB, 8'h0};
    foreach (codes[i]) begin
      act({24'b0, codes[i]});
      chk("R3 latch", {56'b0, eng_op}, {56'b0, codes[i]});
    end
  endtask

  task automatic t_copy;
    wr(4'h8, 64'h0000000012345678, 1'b1);
    act(32'h4);
    chk("R4 offset", {32'b0, eng_offset}, 64'h12345678);
    wr(4'h8, 64'hDEADBEEF00000042, 1'b1);
    act(32'h9);
    chk("R4 id", eng_rec_id, 64'hDEADBEEF00000042);
  endtask

  task automatic t_engine;
    logic [63:0] v;
    act(32'h1);
    wr(4'h8, 64'h9C, 1'b1);
    act(32'h5);
    chk("R5 start", {63'b0, eng_start}, 64'h1);
    @(negedge clk);
    chk("R5 one pulse", {63'b0, eng_start}, 64'h0);
    query(32'h6, v);    chk("R11 busy query", v, 64'h1);
    act(32'h9);
    chk("R11 id locked", eng_rec_id, 64'hDEADBEEF00000042);
    act(32'h2);
    chk("R11 op locked", {56'b0, eng_op}, 64'h1);
    eng_done = 1'b1; eng_status = 8'd5;
    @(negedge clk);
    eng_done = 1'b0; eng_status = 8'd0;
    query(32'h7, v);    chk("R5 status capture", v, 64'h5);
    query(32'h6, v);    chk("R5 busy clear", v, 64'h0);
  endtask

  task automatic t_nokey;
    logic [63:0] v;
    wr(4'h8, 64'h9D, 1'b1);
    act(32'h5);
    chk("R6 no start", {63'b0, eng_start}, 64'h0);
    @(negedge clk);
    chk("R6 no start later", {63'b0, eng_start}, 64'h0);
    query(32'h6, v);    chk("R6 not busy", v, 64'h0);
    query(32'h7, v);    chk("R6 status kept", v, 64'h5);
  endtask

  task automatic t_local;
    logic [63:0] v;
    act(32'hB);
    wr(4'h8, 64'h9C, 1'b1);
    act(32'h5);
    chk("R7 dummy no start", {63'b0, eng_start}, 64'h0);
    query(32'h7, v);    chk("R7 dummy ok", v, 64'h0);
    act(32'h3);
    wr(4'h8, 64'h9C, 1'b1);
    act(32'h5);
    chk("R7 end no start", {63'b0, eng_start}, 64'h0);
    query(32'h6, v);    chk("R7 end not busy", v, 64'h0);
  endtask

  task automatic t_query;
    logic [63:0] v;
    query(32'hA, v);    chk("R8 count", v, 64'd37);
    query(32'hE, v);    chk("R8 size", v, 64'd8192);
    wr(4'h8, 64'h5555, 1'b1);
    query(32'hF, v);    chk("R8 attr", v, 64'h0);
    query(32'h10, v);   chk("R9 timing", v, {32'd100, 32'd10});
  endtask

  task automatic t_ignore;
    logic [63:0] v;
    wr(4'h8, 64'h0BADF00D00000077, 1'b1);
    act(32'h7F);
    rd(4'h8, 1'b1, v);  chk("R10 unknown code", v, 64'h0BADF00D00000077);
    chk("R10 unknown op", {56'b0, eng_op}, 64'h3);
    wr(4'h4, 64'h4, 1'b0);
    chk("R10 offset 4", {32'b0, eng_offset}, 64'h12345678);
    wr(4'h9, 64'h1, 1'b0);
    rd(4'h8, 1'b1, v);  chk("R10 unaligned", v, 64'h0BADF00D00000077);
    wr(4'hC, 64'hFFFFFFFFFFFFFFFF, 1'b1);
    rd(4'h8, 1'b1, v);  chk("R10 wide at 12", v, 64'h0BADF00D00000077);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_merge;
    t_latch;
    t_copy;
    t_engine;
    t_nokey;
    t_local;
    t_query;
    t_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule